// File: doc/BRIEF.md
# Sixteen-bit waveform-mode timer/counter

This peripheral holds a 16-bit up-counter. A 4-bit mode code sets how the counter behaves and which value ends each cycle (TOP). TOP can be a fixed constant of 8, 9, 10 or 16 bits, compare register A, or the capture register. A clock-select field either stops the counter or lets it advance on a prescaled tick. Two compare channels, A and B, raise flags when the counter equals their value. In the PWM modes they also drive pulse-width outputs. Four sticky flags record overflow, compare A, compare B and capture-TOP events.

Software reaches every register over a byte-wide write bus. Each 16-bit register is written as two bytes. The high byte goes first into a temporary byte shared by all registers. The later low-byte write then commits all 16 bits in one clock. The capture register is written only over the bus, because the pin edge logic lies outside this block. The counter value, the flags and both PWM outputs come out as ports.

Top module: `wgm_timer16`

## Requirements
- R1: After reset the count is 0, all flags are 0, both PWM outputs are low, and the mode code and clock select are both 0.
- R2: Mode 0 counts up through 0xFFFF and wraps to 0, so its period is 65536 ticks.
- R3: Mode 4 clears on compare with TOP = compare A. Mode 12 clears on compare with TOP = capture register. In both, the counter goes TOP -> 0 and the period is TOP+1 ticks.
- R4: Modes 5, 6 and 7 are fast PWM with fixed TOP 0x00FF, 0x01FF and 0x03FF, so their periods are 256, 512 and 1024 ticks.
- R5: Mode 14 is PWM with TOP = capture register. Mode 15 is PWM with TOP = compare A. Each has a period of TOP+1 ticks.
- R6: Mode codes 1, 2, 3, 8, 9, 10, 11 and 13 are invalid. The counter holds its value while the mode code is invalid.
- R7: The control register is at address 0, with the mode code in bits 3:0 and the clock select in bits 6:4. Select 0 stops the counter. Selects 1 to 5 give one tick per 1, 8, 64, 256 and 1024 clocks. Selects 6 and 7 also stop the counter.
- R8: The register addresses are: counter 1 (low byte) and 2 (high byte), compare A 3/4, compare B 5/6, capture 7/8. A high-byte write changes no visible value. The matching low-byte write loads {high byte, low byte} in one clock. A counter load takes priority over counting.
- R9: Flag bit 0 (overflow) is set when the counter wraps at TOP in modes 0, 5, 6, 7, 14 and 15. It is not set by the wrap in modes 4 and 12.
- R10: Flag bit 1 is set on a tick at which the count equals compare A. Flag bit 2 is set on a tick at which the count equals compare B.
- R11: Writing to address 9 clears each flag whose bit is 1 in the data. Flags whose bit is 0 are kept. A flag that sets in the same clock as a clear stays set.
- R12: Flag bit 3 (capture) is set when the counter wraps at TOP in modes 12 and 14.
- R13: In modes 5, 6, 7 and 14, output A is high while count < compare A, and output B is high while count < compare B.
- R14: In mode 15, output A stays low and output B follows R13. In every mode that is not a PWM mode, both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register byte address |
| wr_data | input | 8 | Register write data |
| count | output | 16 | Current counter value |
| flags | output | 4 | Sticky flags: bit 0 overflow, bit 1 compare A, bit 2 compare B, bit 3 capture |
| pwm_a | output | 1 | Channel A pulse-width output |
| pwm_b | output | 1 | Channel B pulse-width output |

## Verification
The hardest case to reach from the ports is a clean measurement of one whole cycle, TOP+1 ticks, in each mode. If the mode changes while the counter runs, the counter can pass the new TOP or wrap early, and that spoils the interval. The stimulus therefore stops the counter with select 0 and sets the mode and TOP source. It then loads the counter with TOP itself and restarts it. The first tick is then a wrap, and the monitor times the gap to the next wrap, which tests mode 0's full 65536-tick cycle in a single pass. Prescale ratios are checked over a window of exactly whole tick intervals, so the result does not depend on the prescaler's phase.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  localparam int CNT_W = 16;
  localparam int PRE_W = 10;
  localparam int FLG_W = 4;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_CNT_LO = 4'd1;
  localparam logic [3:0] A_CNT_HI = 4'd2;
  localparam logic [3:0] A_CPA_LO = 4'd3;
  localparam logic [3:0] A_CPA_HI = 4'd4;
  localparam logic [3:0] A_CPB_LO = 4'd5;
  localparam logic [3:0] A_CPB_HI = 4'd6;
  localparam logic [3:0] A_CAP_LO = 4'd7;
  localparam logic [3:0] A_CAP_HI = 4'd8;
  localparam logic [3:0] A_FCLR   = 4'd9;

  typedef enum logic [1:0] {K_OFF, K_NORMAL, K_CLEAR, K_PWM} kind_e;
  typedef enum logic [1:0] {T_FIXED, T_CMPA, T_CAPT} topsrc_e;

  typedef struct packed {
    kind_e             kind;
    topsrc_e           src;
    logic [CNT_W-1:0]  fixed;
  } mode_t;

  function automatic logic [CNT_W-1:0] ones_top(input int bits);
    return CNT_W'((33'd1 << bits) - 33'd1);
  endfunction

  function automatic mode_t mk_mode(input kind_e k, input topsrc_e s, input logic [CNT_W-1:0] f);
    mode_t m;
    m.kind  = k;
    m.src   = s;
    m.fixed = f;
    return m;
  endfunction

  function automatic mode_t decode_mode(input logic [3:0] code);
    case (code)
      4'd0:    return mk_mode(K_NORMAL, T_FIXED, ones_top(CNT_W));
      4'd4:    return mk_mode(K_CLEAR,  T_CMPA,  '0);
      4'd12:   return mk_mode(K_CLEAR,  T_CAPT,  '0);
      4'd5:    return mk_mode(K_PWM,    T_FIXED, ones_top(8));
      4'd6:    return mk_mode(K_PWM,    T_FIXED, ones_top(9));
      4'd7:    return mk_mode(K_PWM,    T_FIXED, ones_top(10));
      4'd14:   return mk_mode(K_PWM,    T_CAPT,  '0);
      4'd15:   return mk_mode(K_PWM,    T_CMPA,  '0);
      default: return mk_mode(K_OFF,    T_FIXED, ones_top(CNT_W));
    endcase
  endfunction

  function automatic logic presc_on(input logic [2:0] sel);
    return (sel >= 3'd1) && (sel <= 3'd5);
  endfunction

  function automatic logic [PRE_W-1:0] presc_mask(input logic [2:0] sel);
    case (sel)
      3'd2:    return PRE_W'(7);
      3'd3:    return PRE_W'(63);
      3'd4:    return PRE_W'(255);
      3'd5:    return PRE_W'(1023);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [3:0]       mode_code,
  output logic [2:0]       clk_sel,
  output logic [CNT_W-1:0] cmp_a,
  output logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] capt,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_load_val,
  output logic [FLG_W-1:0] flag_clr
);
  localparam int HI_W = CNT_W - 8;

  logic [HI_W-1:0] hi_tmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_tmp    <= '0;
      mode_code <= '0;
      clk_sel   <= '0;
      cmp_a     <= '0;
      cmp_b     <= '0;
      capt      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          mode_code <= wr_data[3:0];
          clk_sel   <= wr_data[6:4];
        end
        A_CNT_HI, A_CPA_HI, A_CPB_HI, A_CAP_HI: hi_tmp <= wr_data[HI_W-1:0];
        A_CPA_LO: cmp_a <= {hi_tmp, wr_data};
        A_CPB_LO: cmp_b <= {hi_tmp, wr_data};
        A_CAP_LO: capt  <= {hi_tmp, wr_data};
        default: ;
      endcase
    end
  end

  assign cnt_load     = wr_en && (wr_addr == A_CNT_LO);
  assign cnt_load_val = {hi_tmp, wr_data};
  assign flag_clr     = (wr_en && (wr_addr == A_FCLR)) ? wr_data[FLG_W-1:0] : '0;

endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_cnt <= '0;
    else        pre_cnt <= pre_cnt + PRE_W'(1);
  end

  assign mask = presc_mask(clk_sel);
  assign tick = presc_on(clk_sel) && ((pre_cnt & mask) == mask);

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  mode_t            md,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] capt,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_ovf,
  output logic             ev_cmpa,
  output logic             ev_cmpb,
  output logic             ev_capt,
  output logic             pwm_a,
  output logic             pwm_b
);
  logic [CNT_W-1:0] top;
  logic             step;
  logic             at_top;
  logic             en_a;
  logic             en_b;

  always_comb begin
    case (md.src)
      T_CMPA:  top = cmp_a;
      T_CAPT:  top = capt;
      default: top = md.fixed;
    endcase
  end

  assign step   = tick && (md.kind != K_OFF);
  assign at_top = (cnt == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (step)  cnt <= at_top ? '0 : cnt + CNT_W'(1);
  end

  assign ev_ovf  = step && at_top && (md.kind != K_CLEAR);
  assign ev_capt = step && at_top && (md.src == T_CAPT);
  assign ev_cmpa = step && (cnt == cmp_a);
  assign ev_cmpb = step && (cnt == cmp_b);

  assign en_b  = (md.kind == K_PWM);
  assign en_a  = en_b && (md.src != T_CMPA);
  assign pwm_a = en_a && (cnt < cmp_a);
  assign pwm_b = en_b && (cnt < cmp_b);

  // R2 / R3: a tick at TOP without a load brings the counter back to zero
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_top && !load) |=> (cnt == '0));

  // R6: invalid mode keeps the count frozen unless software loads it
  a_r6_invalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((md.kind == K_OFF) && !load) |=> $stable(cnt));

  // R14: in a mode with compare A as TOP, channel A never pulses
  a_r14_no_duty_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    (md.src == T_CMPA) |-> !pwm_a);

endmodule

// File: rtl/wgm_timer16.sv
module wgm_timer16
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [CNT_W-1:0] count,
  output logic [FLG_W-1:0] flags,
  output logic             pwm_a,
  output logic             pwm_b
);
  logic [3:0]       mode_code;
  logic [2:0]       clk_sel;
  logic [CNT_W-1:0] cmp_a, cmp_b, capt, cnt_load_val;
  logic             cnt_load;
  logic [FLG_W-1:0] flag_clr;
  logic [FLG_W-1:0] flag_set;
  logic             tick;
  mode_t            md;
  logic             ev_ovf, ev_cmpa, ev_cmpb, ev_capt;

  tmr16_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .mode_code    (mode_code),
    .clk_sel      (clk_sel),
    .cmp_a        (cmp_a),
    .cmp_b        (cmp_b),
    .capt         (capt),
    .cnt_load     (cnt_load),
    .cnt_load_val (cnt_load_val),
    .flag_clr     (flag_clr)
  );

  tmr16_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_sel (clk_sel),
    .tick    (tick)
  );

  assign md = decode_mode(mode_code);

  tmr16_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .md       (md),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .capt     (capt),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .cnt      (count),
    .ev_ovf   (ev_ovf),
    .ev_cmpa  (ev_cmpa),
    .ev_cmpb  (ev_cmpb),
    .ev_capt  (ev_capt),
    .pwm_a    (pwm_a),
    .pwm_b    (pwm_b)
  );

  assign flag_set = {ev_capt, ev_cmpb, ev_cmpa, ev_ovf};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;
  end

  // R7: select 0 freezes the count unless loaded
  a_r7_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_sel == 3'd0) && !cnt_load) |=> $stable(count));

  // R8: a high-byte counter write alone leaves the count untouched
  a_r8_hi_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_CNT_HI) && !tick) |=> $stable(count));

  // R9: an overflow event is visible in the flag one clock later
  a_r9_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovf |=> flags[0]);

  // R10: compare A event is latched
  a_r10_cmpa_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmpa |=> flags[1]);

  // R11: a clear without a simultaneous set empties the flag
  a_r11_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[0] && !ev_ovf) |=> !flags[0]);

endmodule

// File: tb/wgm_timer16_test.sv
`timescale 1ns/1ps
module wgm_timer16_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count;
  logic [3:0]  flags;
  logic        pwm_a, pwm_b;

  int checks = 0, bad = 0;
  int mon_checks = 0, mon_bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  wgm_timer16 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .flags(flags), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo_addr, input logic [15:0] v);
    wr(lo_addr + 4'd1, v[15:8]);
    wr(lo_addr, v[7:0]);
  endtask

  task automatic ctrl(input logic [3:0] mode, input logic [2:0] sel);
    wr(4'd0, {1'b0, sel, mode});
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: stop, preload TOP, queue expected period, restart
  task automatic period(input string req, input logic [3:0] mode, input logic [15:0] top);
    ctrl(mode, 3'd0);
    wr16(4'd1, top);
    exp_q.push_back(int'(top) + 1);
    tag_q.push_back(req);
    ctrl(mode, 3'd1);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic duty(input string req, input int win, input int exp_a, input int exp_b);
    int ha = 0, hb = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end
    check({req, " duty A"}, ha, exp_a);
    check({req, " duty B"}, hb, exp_b);
  endtask

  // monitor: times the gap between consecutive wraps and scores it
  logic [15:0] prev_cnt = '0;
  bit          seen = 0;
  int          gap = 0;
  always @(negedge clk) begin
    if (exp_q.size() == 0) begin
      seen = 0;
    end else begin
      if (seen) gap = gap + 1;
      if (count == 16'd0 && prev_cnt != 16'd0) begin
        if (seen) begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          mon_checks++;
          if (gap != e) begin
            mon_bad++;
            $display("FAIL %s period: actual=%0d expected=%0d", t, gap, e);
          end
          seen = 0;
        end else begin
          seen = 1;
          gap = 0;
        end
      end
    end
    prev_cnt = count;
  end

  initial begin : watchdog
    for (int i = 0; i < 190000; i++) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", checks + mon_checks + 1, bad + mon_bad);
    $finish;
  end

  initial begin : stim
    logic [15:0] c0;
    waitn(3);
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 flags", flags, 0);
    check("R1 pwm", {pwm_a, pwm_b}, 0);
    rst_n = 1'b1;
    waitn(5);
    check("R1 stopped after reset", count, 0);

    // R8 byte access with the counter stopped
    wr(4'd2, 8'h12);
    check("R8 high byte alone", count, 0);
    wr(4'd1, 8'h34);
    check("R8 low byte commits", count, 16'h1234);

    // R6 invalid modes hold
    ctrl(4'd1, 3'd1);
    waitn(20);
    check("R6 mode 1 hold", count, 16'h1234);
    ctrl(4'd13, 3'd1);
    waitn(20);
    check("R6 mode 13 hold", count, 16'h1234);

    // R7 clock select
    ctrl(4'd0, 3'd0);
    waitn(30);
    check("R7 select 0 stop", count, 16'h1234);
    ctrl(4'd0, 3'd6);
    waitn(30);
    check("R7 select 6 stop", count, 16'h1234);
    ctrl(4'd0, 3'd3);
    c0 = count;
    waitn(128);
    check("R7 divide by 64", int'(count - c0), 2);
    ctrl(4'd0, 3'd2);
    c0 = count;
    waitn(64);
    check("R7 divide by 8", int'(count - c0), 8);
    ctrl(4'd0, 3'd1);
    c0 = count;
    waitn(10);
    check("R7 divide by 1", int'(count - c0), 10);

    // R2..R5 periods at prescaler 1
    period("R2", 4'd0, 16'hFFFF);
    period("R4 mode 5", 4'd5, 16'h00FF);
    period("R4 mode 6", 4'd6, 16'h01FF);
    period("R4 mode 7", 4'd7, 16'h03FF);
    wr16(4'd3, 16'h0040);
    period("R3 mode 4", 4'd4, 16'h0040);
    wr16(4'd7, 16'h0030);
    period("R3 mode 12", 4'd12, 16'h0030);
    wr16(4'd7, 16'h0050);
    period("R5 mode 14", 4'd14, 16'h0050);
    wr16(4'd3, 16'h0025);
    period("R5 mode 15", 4'd15, 16'h0025);

    // R9 overflow in fast PWM, R11 clear
    ctrl(4'd5, 3'd0);
    wr16(4'd1, 16'h00FE);
    wr(4'd9, 8'h0F);
    check("R11 clear all", flags, 0);
    ctrl(4'd5, 3'd1);
    waitn(4);
    check("R9 overflow set", flags[0], 1);

    // R10 compare flags and R9 none in CTC
    ctrl(4'd4, 3'd0);
    wr16(4'd3, 16'h0040);
    wr16(4'd5, 16'h0020);
    wr16(4'd1, 16'h0000);
    wr(4'd9, 8'h0F);
    ctrl(4'd4, 3'd1);
    waitn(48);
    check("R10 compare B set", flags[2], 1);
    check("R10 compare A not yet", flags[1], 0);
    waitn(32);
    check("R10 compare A set", flags[1], 1);
    check("R9 no overflow in CTC", flags[0], 0);
    check("R12 no capture flag in mode 4", flags[3], 0);
    check("R14 CTC outputs low", {pwm_a, pwm_b}, 0);
    // R11 partial clear keeps other bits
    ctrl(4'd4, 3'd0);
    wr(4'd9, 8'h02);
    check("R11 partial clear", flags, 4'b0100);

    // R12 capture flag in mode 12
    wr16(4'd7, 16'h0030);
    ctrl(4'd12, 3'd0);
    wr16(4'd1, 16'h0000);
    wr(4'd9, 8'h0F);
    ctrl(4'd12, 3'd1);
    waitn(64);
    check("R12 capture flag", flags[3], 1);
    check("R9 no overflow in mode 12", flags[0], 0);

    // R13 fast PWM duty
    wr16(4'd3, 16'h0040);
    wr16(4'd5, 16'h0080);
    ctrl(4'd5, 3'd1);
    waitn(4);
    duty("R13 mode 5", 256, 64, 128);
    // R13 mode 14 with capture TOP
    wr16(4'd7, 16'h0050);
    wr16(4'd3, 16'h0020);
    wr16(4'd5, 16'h0010);
    ctrl(4'd14, 3'd0);
    wr16(4'd1, 16'h0000);
    ctrl(4'd14, 3'd1);
    duty("R13 mode 14", 81, 32, 16);
    // R14 mode 15: channel A silent
    wr16(4'd3, 16'h0025);
    ctrl(4'd15, 3'd0);
    wr16(4'd1, 16'h0000);
    ctrl(4'd15, 3'd1);
    duty("R14 mode 15", 38, 0, 16);

    $display("test done: total=%0d bad=%0d", checks + mon_checks, bad + mon_bad);
    $finish;
  end
endmodule